// File: doc/BRIEF.md
# PWM Period Reconfiguration Sequencer

This block changes the period of a shared PWM timer unit whose counter, prescaler and modulus serve several output channels at once. A caller hands it a target period measured in undivided system-clock ticks together with a mask of the channels that are in use. The block works out the finest prescaler whose 16-bit counter can still span that period. It derives the new modulus and then drives a fixed register sequence on the timer through a simple register master port. During that sequence each in-use channel's compare value is scaled so that its duty ratio stays the same under the new period.

The caller raises `req_valid` for one cycle while `busy` is low. It then waits for the one-cycle `done` pulse. When the computed modulus already matches the timer and the timer is already counting, the request finishes without touching the timer at all. This avoids cutting a running cycle short. Compare values are rescaled with exact integer arithmetic, using one shared sequential divider.

Top module: `pwm_period_sequencer`

## Requirements
- R1: The prescaler exponent `ps` (divide by 2^ps) is the smallest value in 0..7 for which the requested tick count is no greater than 65535·2^ps. When no exponent satisfies this, the block uses 7.
- R2: The new modulus is (ticks >> ps) − 1. A shift result of zero gives modulus 0, and a result above 65536 saturates the modulus at 65535.
- R3: When the new modulus equals the modulus read from the timer and the control register's clock-mode field (bits 4:3) reads 01, the request ends with `done` and the block makes no register writes.
- R4: Before any other write, the block writes the control register with bits 4:0 cleared and its upper bits kept. It reads the register back and repeats this write/read pair until bits 4:0 read zero.
- R5: For each channel n set in the mask, the compare register at address 4+n becomes floor(min(old, oldMod+1)·(newMod+1)/(oldMod+1)). Compare registers of channels outside the mask are never written.
- R6: A rescaled compare value is written only if it differs from the value read.
- R7: After all channels are handled, the block writes 0 to the counter (address 1), then the new modulus to address 2, then control (address 0) with bits 4:3 = 01 and bits 2:0 = ps. This control write is the last bus access of the request.
- R8: `busy` rises in the cycle after a request is accepted and stays high through the final write. In the next cycle `busy` is low and `done` pulses for one cycle. A `req_valid` that arrives while `busy` is high has no effect.
- R9: Bus reads take `tmr_rdata` in the same cycle as `tmr_en` with `tmr_we` low. Writes take effect at the clock edge that ends the access cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, accepted while idle |
| req_ticks | input | TICK_W (32) | Requested period in system-clock ticks |
| req_chan_mask | input | CHAN_N (6) | Channels whose duty ratio is kept |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| tmr_en | output | 1 | Timer register access this cycle |
| tmr_we | output | 1 | Access is a write |
| tmr_addr | output | 4 | Timer register address |
| tmr_wdata | output | 32 | Write data |
| tmr_rdata | input | 32 | Read data, same cycle |

## Verification
The assertions watch properties that hold on every cycle: the bus stays quiet while idle, the `done` pulse lasts one cycle and closes `busy`, and the first write of a request is always a stop word. They also check that the counter is only ever written with zero, that compare writes go only to masked channels and never exceed full scale, and that the run word is always the final access. The actual numbers can only be shown by the bench scenarios against a register model of the timer: the chosen prescaler at the 65535/65536 boundary, the saturated and zero-clamped moduli, and the rescaled compare values. The same holds for the skipped no-change request, the stop retry against a control register that ignores writes, and a request ignored while busy.

// File: rtl/pwmseq_pkg.sv
package pwmseq_pkg;

    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 4;
    localparam int PS_W        = 3;
    localparam int PS_STEPS    = 8;
    localparam int CTRL_LOW_W  = 5;

    localparam logic [1:0]        MODE_RUN   = 2'b01;
    localparam logic [ADDR_W-1:0] A_CTRL     = 4'd0;
    localparam logic [ADDR_W-1:0] A_COUNT    = 4'd1;
    localparam logic [ADDR_W-1:0] A_MOD      = 4'd2;
    localparam logic [ADDR_W-1:0] A_CMP_BASE = 4'd4;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_CTRL,
        S_RD_MOD,
        S_DECIDE,
        S_STOP_WR,
        S_STOP_RD,
        S_CH_SEL,
        S_CH_RD,
        S_CH_GO,
        S_CH_WAIT,
        S_CH_WR,
        S_CNT_CLR,
        S_MOD_WR,
        S_CTRL_WR
    } seq_state_e;

    typedef struct packed {
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_cmd_t;

    function automatic logic [DATA_W-1:0] stop_word(input logic [DATA_W-1:0] cur);
        return cur & ~DATA_W'({CTRL_LOW_W{1'b1}});
    endfunction

    function automatic logic [DATA_W-1:0] run_word(input logic [PS_W-1:0] ps);
        return DATA_W'({MODE_RUN, ps});
    endfunction

    function automatic logic clock_running(input logic [DATA_W-1:0] ctrl);
        return ctrl[PS_W+1:PS_W] == MODE_RUN;
    endfunction

endpackage

// File: rtl/pwmseq_scale_calc.sv
module pwmseq_scale_calc
    import pwmseq_pkg::*;
#(
    parameter int TICK_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic [TICK_W-1:0] ticks,
    output logic [PS_W-1:0]   ps,
    output logic [CNT_W-1:0]  modulus
);
    localparam logic [TICK_W-1:0] CNT_MAX = TICK_W'((64'd1 << CNT_W) - 64'd1);

    logic [PS_STEPS-1:0] fits;
    logic [TICK_W-1:0]   shifted;
    logic [TICK_W-1:0]   minus_one;

    for (genvar p = 0; p < PS_STEPS; p++) begin : g_fit
        localparam logic [TICK_W-1:0] LIMIT = CNT_MAX << p;
        assign fits[p] = (ticks <= LIMIT);
    end

    always_comb begin
        ps = PS_W'(PS_STEPS - 1);
        for (int i = PS_STEPS - 1; i >= 0; i--) begin
            if (fits[i]) ps = PS_W'(i);
        end
    end

    always_comb begin
        shifted   = ticks >> ps;
        minus_one = shifted - TICK_W'(1);
        if (shifted == '0)
            modulus = '0;
        else if (minus_one > CNT_MAX)
            modulus = '1;
        else
            modulus = minus_one[CNT_W-1:0];
    end

endmodule

// File: rtl/pwmseq_divider.sv
module pwmseq_divider #(
    parameter int NUM_W = 34,
    parameter int DEN_W = 17,
    parameter int QUO_W = 17
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [QUO_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] quo_q;
    logic [DEN_W-1:0] rem_q;
    logic [DEN_W-1:0] den_q;
    logic [CNT_W-1:0] steps_q;
    logic             run_q;
    logic [DEN_W:0]   trial;
    logic             take;

    assign trial = {rem_q, quo_q[NUM_W-1]};
    assign take  = (trial >= {1'b0, den_q});
    assign quo   = quo_q[QUO_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            quo_q   <= '0;
            rem_q   <= '0;
            den_q   <= '0;
            steps_q <= '0;
            run_q   <= 1'b0;
            done    <= 1'b0;
        end else if (start) begin
            quo_q   <= num;
            rem_q   <= '0;
            den_q   <= den;
            steps_q <= CNT_W'(NUM_W);
            run_q   <= 1'b1;
            done    <= 1'b0;
        end else if (run_q) begin
            rem_q   <= take ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
            quo_q   <= {quo_q[NUM_W-2:0], take};
            steps_q <= steps_q - CNT_W'(1);
            if (steps_q == CNT_W'(1)) begin
                run_q <= 1'b0;
                done  <= 1'b1;
            end
        end else begin
            done <= 1'b0;
        end
    end

endmodule

// File: rtl/pwm_period_sequencer.sv
module pwm_period_sequencer
    import pwmseq_pkg::*;
#(
    parameter int TICK_W = 32,
    parameter int CNT_W  = 16,
    parameter int CHAN_N = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [TICK_W-1:0] req_ticks,
    input  logic [CHAN_N-1:0] req_chan_mask,
    output logic              busy,
    output logic              done,
    output logic              tmr_en,
    output logic              tmr_we,
    output logic [ADDR_W-1:0] tmr_addr,
    output logic [DATA_W-1:0] tmr_wdata,
    input  logic [DATA_W-1:0] tmr_rdata
);
    localparam int CMP_W = CNT_W + 1;
    localparam int NUM_W = 2 * CMP_W;
    localparam int CH_W  = $clog2(CHAN_N + 1);

    seq_state_e        state;
    logic [TICK_W-1:0] ticks_q;
    logic [CHAN_N-1:0] mask_q;
    logic [DATA_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  old_mod_q;
    logic [CMP_W-1:0]  old_cmp_q;
    logic [CH_W-1:0]   ch_idx;

    logic [PS_W-1:0]   new_ps;
    logic [CNT_W-1:0]  new_mod;
    logic [CMP_W-1:0]  old_span;
    logic [CMP_W-1:0]  new_span;
    logic [CMP_W-1:0]  eff_cmp;
    logic [NUM_W-1:0]  div_num;
    logic              div_start;
    logic              div_done;
    logic [CMP_W-1:0]  div_quo;
    logic              ch_end;
    logic              ch_active;
    logic              cmp_changed;
    logic [ADDR_W-1:0] ch_addr;
    bus_cmd_t          cmd;

    pwmseq_scale_calc #(
        .TICK_W (TICK_W),
        .CNT_W  (CNT_W)
    ) u_calc (
        .ticks   (ticks_q),
        .ps      (new_ps),
        .modulus (new_mod)
    );

    assign old_span = {1'b0, old_mod_q} + CMP_W'(1);
    assign new_span = {1'b0, new_mod} + CMP_W'(1);
    assign eff_cmp  = (old_cmp_q > old_span) ? old_span : old_cmp_q;
    assign div_num  = NUM_W'(eff_cmp) * NUM_W'(new_span);

    pwmseq_divider #(
        .NUM_W (NUM_W),
        .DEN_W (CMP_W),
        .QUO_W (CMP_W)
    ) u_div (
        .clk   (clk),
        .rst   (rst),
        .start (div_start),
        .num   (div_num),
        .den   (old_span),
        .done  (div_done),
        .quo   (div_quo)
    );

    assign ch_end      = (ch_idx == CH_W'(CHAN_N));
    assign ch_active   = !ch_end && mask_q[ch_idx];
    assign cmp_changed = (div_quo != old_cmp_q);
    assign ch_addr     = A_CMP_BASE + ADDR_W'(ch_idx);
    assign div_start   = (state == S_CH_GO);
    assign busy        = (state != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            ticks_q   <= '0;
            mask_q    <= '0;
            ctrl_q    <= '0;
            old_mod_q <= '0;
            old_cmp_q <= '0;
            ch_idx    <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        ticks_q <= req_ticks;
                        mask_q  <= req_chan_mask;
                        state   <= S_RD_CTRL;
                    end
                end
                S_RD_CTRL: begin
                    ctrl_q <= tmr_rdata;
                    state  <= S_RD_MOD;
                end
                S_RD_MOD: begin
                    old_mod_q <= tmr_rdata[CNT_W-1:0];
                    state     <= S_DECIDE;
                end
                S_DECIDE: begin
                    if (new_mod == old_mod_q && clock_running(ctrl_q)) begin
                        done  <= 1'b1;
                        state <= S_IDLE;
                    end else begin
                        state <= S_STOP_WR;
                    end
                end
                S_STOP_WR: state <= S_STOP_RD;
                S_STOP_RD: begin
                    ctrl_q <= tmr_rdata;
                    if (tmr_rdata[CTRL_LOW_W-1:0] != '0) begin
                        state <= S_STOP_WR;
                    end else begin
                        ch_idx <= '0;
                        state  <= S_CH_SEL;
                    end
                end
                S_CH_SEL: begin
                    if (ch_end)
                        state <= S_CNT_CLR;
                    else if (ch_active)
                        state <= S_CH_RD;
                    else
                        ch_idx <= ch_idx + CH_W'(1);
                end
                S_CH_RD: begin
                    old_cmp_q <= tmr_rdata[CMP_W-1:0];
                    state     <= S_CH_GO;
                end
                S_CH_GO: state <= S_CH_WAIT;
                S_CH_WAIT: begin
                    if (div_done) state <= S_CH_WR;
                end
                S_CH_WR: begin
                    ch_idx <= ch_idx + CH_W'(1);
                    state  <= S_CH_SEL;
                end
                S_CNT_CLR: state <= S_MOD_WR;
                S_MOD_WR:  state <= S_CTRL_WR;
                S_CTRL_WR: begin
                    done  <= 1'b1;
                    state <= S_IDLE;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        cmd = '{en: 1'b0, we: 1'b0, addr: A_CTRL, wdata: '0};
        unique case (state)
            S_RD_CTRL: cmd = '{en: 1'b1, we: 1'b0, addr: A_CTRL, wdata: '0};
            S_RD_MOD:  cmd = '{en: 1'b1, we: 1'b0, addr: A_MOD, wdata: '0};
            S_STOP_WR: cmd = '{en: 1'b1, we: 1'b1, addr: A_CTRL, wdata: stop_word(ctrl_q)};
            S_STOP_RD: cmd = '{en: 1'b1, we: 1'b0, addr: A_CTRL, wdata: '0};
            S_CH_RD:   cmd = '{en: 1'b1, we: 1'b0, addr: ch_addr, wdata: '0};
            S_CH_WR:   cmd = '{en: cmp_changed, we: cmp_changed, addr: ch_addr,
                               wdata: DATA_W'(div_quo)};
            S_CNT_CLR: cmd = '{en: 1'b1, we: 1'b1, addr: A_COUNT, wdata: '0};
            S_MOD_WR:  cmd = '{en: 1'b1, we: 1'b1, addr: A_MOD, wdata: DATA_W'(new_mod)};
            S_CTRL_WR: cmd = '{en: 1'b1, we: 1'b1, addr: A_CTRL, wdata: run_word(new_ps)};
            default:   cmd = '{en: 1'b0, we: 1'b0, addr: A_CTRL, wdata: '0};
        endcase
    end

    assign tmr_en    = cmd.en;
    assign tmr_we    = cmd.we;
    assign tmr_addr  = cmd.addr;
    assign tmr_wdata = cmd.wdata;

endmodule

// File: rtl/pwm_period_sequencer_chk.sv
module pwm_period_sequencer_chk
    import pwmseq_pkg::*;
#(
    parameter int CHAN_N = 6,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [CHAN_N-1:0] req_chan_mask,
    input logic              busy,
    input logic              done,
    input logic              tmr_en,
    input logic              tmr_we,
    input logic [ADDR_W-1:0] tmr_addr,
    input logic [DATA_W-1:0] tmr_wdata
);
    logic [CHAN_N-1:0] mask_seen;
    logic              wrote_any;
    logic              wr;
    logic              cmp_range;
    logic              cmp_hit;
    logic [ADDR_W-1:0] cmp_off;

    assign wr        = tmr_en && tmr_we;
    assign cmp_off   = tmr_addr - A_CMP_BASE;
    assign cmp_range = (tmr_addr >= A_CMP_BASE) && (cmp_off < ADDR_W'(CHAN_N));
    assign cmp_hit   = cmp_range && mask_seen[cmp_off[$clog2(CHAN_N)-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_seen <= '0;
            wrote_any <= 1'b0;
        end else if (req_valid && !busy) begin
            mask_seen <= req_chan_mask;
            wrote_any <= 1'b0;
        end else if (wr) begin
            wrote_any <= 1'b1;
        end
    end

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !tmr_en) else $error("bus active while idle"); // R8
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("done longer than one cycle"); // R8
    AST_DONE_CLOSES_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy))) else $error("done without busy"); // R8
    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |=> busy) else $error("request not accepted"); // R8
    AST_STOP_FIRST: assert property (@(posedge clk) disable iff (rst)
        (wr && !wrote_any) |-> (tmr_addr == A_CTRL && tmr_wdata[CTRL_LOW_W-1:0] == '0))
        else $error("first write is not a stop word"); // R4
    AST_RUN_WORD_LAST: assert property (@(posedge clk) disable iff (rst)
        (wr && tmr_addr == A_CTRL && tmr_wdata[PS_W+1:PS_W] == MODE_RUN) |=> done)
        else $error("run word not final"); // R7
    AST_LAST_ACCESS_CTRL: assert property (@(posedge clk) disable iff (rst)
        done |-> (!$past(tmr_en) || ($past(tmr_we) && $past(tmr_addr) == A_CTRL)))
        else $error("final access not control"); // R7
    AST_COUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (wr && tmr_addr == A_COUNT) |-> (tmr_wdata == '0))
        else $error("counter written nonzero"); // R7
    AST_CMP_MASKED: assert property (@(posedge clk) disable iff (rst)
        (wr && tmr_addr >= A_CMP_BASE) |-> cmp_hit)
        else $error("compare write outside mask"); // R5
    AST_CMP_FULL_SCALE: assert property (@(posedge clk) disable iff (rst)
        (wr && cmp_range) |-> (tmr_wdata <= (DATA_W'(1) << CNT_W)))
        else $error("compare above full scale"); // R5

endmodule

bind pwm_period_sequencer pwm_period_sequencer_chk u_chk (.*);

// File: tb/pwm_period_sequencer_tb.sv
module pwm_period_sequencer_tb;
    import pwmseq_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [31:0]       req_ticks = '0;
    logic [5:0]        req_chan_mask = '0;
    logic              busy, done, tmr_en, tmr_we;
    logic [ADDR_W-1:0] tmr_addr;
    logic [DATA_W-1:0] tmr_wdata, tmr_rdata;

    int errors = 0;
    int checks = 0;

    // timer register model
    logic [31:0] regs [16];
    int          wr_total;
    int          wr_per [16];
    logic [3:0]  hist0, hist1, hist2;
    int          lag;
    logic        pl_en = 1'b0;
    logic [3:0]  pl_addr = '0;
    logic [31:0] pl_data = '0;
    logic        log_clr = 1'b0;
    int          lag_set = 0;

    always #2 clk = ~clk;

    pwm_period_sequencer u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ticks(req_ticks),
        .req_chan_mask(req_chan_mask), .busy(busy), .done(done),
        .tmr_en(tmr_en), .tmr_we(tmr_we), .tmr_addr(tmr_addr),
        .tmr_wdata(tmr_wdata), .tmr_rdata(tmr_rdata)
    );

    assign tmr_rdata = regs[tmr_addr];

    always @(posedge clk) begin
        if (pl_en) regs[pl_addr] <= pl_data;
        if (log_clr) begin
            wr_total <= 0;
            for (int i = 0; i < 16; i++) wr_per[i] <= 0;
            hist0 <= 4'hF; hist1 <= 4'hF; hist2 <= 4'hF;
            lag <= lag_set;
        end else if (tmr_en && tmr_we) begin
            wr_total <= wr_total + 1;
            wr_per[tmr_addr] <= wr_per[tmr_addr] + 1;
            hist2 <= hist1; hist1 <= hist0; hist0 <= tmr_addr;
            if (tmr_addr == A_CTRL && lag > 0) lag <= lag - 1;
            else regs[tmr_addr] <= tmr_wdata;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic poke(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk); pl_en = 1'b1; pl_addr = a; pl_data = d;
        @(negedge clk); pl_en = 1'b0;
    endtask

    task automatic setup(input int md, input int ctl, input int lg);
        for (int i = 0; i < 16; i++) poke(4'(i), 32'd0);
        poke(A_MOD, 32'(md));
        poke(A_CTRL, 32'(ctl));
        @(negedge clk); lag_set = lg; log_clr = 1'b1;
        @(negedge clk); log_clr = 1'b0;
    endtask

    task automatic launch(input int tk, input logic [5:0] m);
        @(negedge clk); req_valid = 1'b1; req_ticks = 32'(tk); req_chan_mask = m;
        @(negedge clk); req_valid = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        bit seen = 0;
        for (int i = 0; i < 2000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        chk({tag, " done seen"}, longint'(seen), 1);
    endtask

    task automatic run(input string tag, input int tk, input logic [5:0] m);
        launch(tk, m);
        wait_done(tag);
    endtask

    task automatic t_reset();
        chk("R8 reset busy", longint'(busy), 0);
        chk("R8 reset done", longint'(done), 0);
        chk("R8 reset bus", longint'(tmr_en), 0);
    endtask

    task automatic t_basic();
        setup(999, 32'h08, 0);
        poke(4, 500); poke(5, 123); poke(6, 250); poke(9, 1000);
        run("R5 basic", 4000, 6'b100101);
        chk("R2 basic mod", regs[A_MOD], 3999);
        chk("R1 basic ctrl", regs[A_CTRL], 32'h08);
        chk("R5 cmp0", regs[4], 2000);
        chk("R5 cmp2", regs[6], 1000);
        chk("R5 cmp5 full", regs[9], 4000);
        chk("R5 inactive cmp1", regs[5], 123);
        chk("R8 idle after", longint'(busy), 0);
    endtask

    task automatic t_presc();
        setup(999, 32'h08, 0);
        poke(4, 250);
        run("R1 div4", 200000, 6'b000001);
        chk("R1 ctrl ps2", regs[A_CTRL], 32'h0A);
        chk("R2 mod ps2", regs[A_MOD], 49999);
        chk("R5 cmp ps2", regs[4], 12500);
        setup(999, 32'h08, 0);
        run("R1 edge lo", 65535, 6'b0);
        chk("R1 65535 ctrl", regs[A_CTRL], 32'h08);
        chk("R2 65535 mod", regs[A_MOD], 65534);
        setup(999, 32'h08, 0);
        run("R1 edge hi", 65536, 6'b0);
        chk("R1 65536 ctrl", regs[A_CTRL], 32'h09);
        chk("R2 65536 mod", regs[A_MOD], 32767);
    endtask

    task automatic t_limits();
        setup(999, 32'h08, 0);
        poke(4, 1);
        run("R2 sat", 20000000, 6'b000001);
        chk("R1 ctrl ps7", regs[A_CTRL], 32'h0F);
        chk("R2 mod saturated", regs[A_MOD], 65535);
        chk("R5 cmp sat", regs[4], 65);
        setup(999, 32'h08, 0);
        poke(4, 500);
        run("R2 zero", 0, 6'b000001);
        chk("R2 zero mod", regs[A_MOD], 0);
        chk("R5 zero cmp", regs[4], 0);
    endtask

    task automatic t_skip();
        setup(3999, 32'h08, 0);
        poke(4, 77);
        run("R3 skip", 4000, 6'b111111);
        chk("R3 no writes", wr_total, 0);
        chk("R3 cmp kept", regs[4], 77);
        setup(3999, 32'h00, 0);
        run("R3 stopped", 4000, 6'b0);
        chk("R3 stopped writes", wr_total, 4);
        chk("R3 stopped ctrl", regs[A_CTRL], 32'h08);
    endtask

    task automatic t_clamp_nochange();
        setup(999, 32'h08, 0);
        poke(7, 5000);
        run("R5 clamp", 2000, 6'b001000);
        chk("R5 clamp cmp3", regs[7], 2000);
        setup(999, 32'h08, 0);
        poke(5, 500);
        run("R6 nochange", 2000, 6'b000011);
        chk("R6 zero cmp not written", wr_per[4], 0);
        chk("R6 cmp1 written", wr_per[5], 1);
        chk("R6 cmp1 value", regs[5], 1000);
    endtask

    task automatic t_busy_ignore();
        setup(999, 32'h08, 0);
        poke(4, 100);
        launch(4000, 6'b000001);
        repeat (10) @(negedge clk);
        chk("R8 busy mid", longint'(busy), 1);
        req_valid = 1'b1; req_ticks = 32'd100; req_chan_mask = 6'b000010;
        @(negedge clk); req_valid = 1'b0;
        wait_done("R8 ignore");
        chk("R8 first request kept", regs[A_MOD], 3999);
        chk("R8 cmp from first", regs[4], 400);
        repeat (3) @(negedge clk);
        chk("R8 no second run", longint'(busy), 0);
    endtask

    task automatic t_retry_order();
        setup(999, 32'h08, 3);
        run("R4 retry", 4000, 6'b0);
        chk("R4 ctrl writes", wr_per[A_CTRL], 5);
        chk("R4 final ctrl", regs[A_CTRL], 32'h08);
        chk("R7 third last count", hist2, A_COUNT);
        chk("R7 second last mod", hist1, A_MOD);
        chk("R7 last ctrl", hist0, A_CTRL);
        chk("R9 count cleared", regs[A_COUNT], 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_basic();
        t_presc();
        t_limits();
        t_skip();
        t_clamp_nochange();
        t_busy_ignore();
        t_retry_order();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog R8 actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule